// File: doc/BRIEF.md
# Tagged Granule Load/Store Unit

This block is a word-addressed memory that sits behind a simple core-side request port and keeps one hidden validity tag per 16-byte granule. The tag lets hardware tell whether a pointer or capability held in that granule is still intact. Data moves over a 128-bit path. The core issues byte, 4-byte, 8-byte and 16-byte (quadword) loads and stores. It also owns two single-bit registers: a tags-active mode bit and a tag flag.

Ordinary stores cannot set a tag. Any ordinary store to a granule invalidates that granule's tag. A tag can only be written as 1 by an aligned quadword store made while tags-active mode is on, and in that case the stored tag is copied from the tag flag. An aligned quadword load made in tags-active mode returns the stored tag into the tag flag, so software can test the tag before it trusts the pointer. The tag lives beside the data in the storage that would normally hold check bits. It never appears in any data field.

Top module: `tagmem_lsu`

## Requirements
- R1: After reset, every granule's tag and data are zero, `tags_active` is 0, `tag_flag` is 0 and `rsp_valid` is 0.
- R2: `req_ready` is 1 whenever reset is low. Every accepted request (`req_valid` and `req_ready` both high at a clock edge) produces exactly one `rsp_valid` pulse one cycle later. `rsp_valid` is 0 otherwise.
- R3: Ordinary stores use `req_op` 4 (byte), 5 (4 bytes) and 6 (8 bytes). The data comes from the low bytes of `req_wdata`, and the address low bits below the access size are ignored (natural alignment). Such a store writes only the addressed bytes and clears that granule's tag, in either mode.
- R4: A quadword store (`req_op` 7) with `req_addr[3:0]`==0, made while `tags_active` is 1, writes all 16 bytes. It sets the granule tag to the `tag_flag` value held before that clock edge.
- R5: A quadword load (`req_op` 3) with `req_addr[3:0]`==0, made while `tags_active` is 1, returns the whole granule on `rsp_rdata` and copies the granule tag into `tag_flag`.
- R6: While `tags_active` is 0, an aligned quadword store writes the granule and clears its tag. An aligned quadword load returns the granule and leaves `tag_flag` unchanged.
- R7: Ordinary loads use `req_op` 0 (byte), 1 (4 bytes) and 2 (8 bytes), with naturally aligned addresses. They return the addressed bytes right-justified and zero-extended, with the lowest address in `rsp_rdata[7:0]`. They change neither `tag_flag` nor any tag. Stores return `rsp_rdata` of 0.
- R8: A quadword access with `req_addr[3:0]` not 0 responds with `rsp_align_err`=1 and `rsp_rdata`=0. It leaves memory, tags and `tag_flag` unchanged.
- R9: `mode_we` and `flag_we` load their registers at the clock edge, and a request accepted in the same cycle still sees the old values. When a tags-active quadword load and `flag_we` fall in the same cycle, the load's tag wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 3 | Operation code (see R3, R7, R4, R5) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 128 | Store data, right-justified |
| mode_we | input | 1 | Write strobe for tags-active mode |
| mode_wdata | input | 1 | New tags-active value |
| flag_we | input | 1 | Write strobe for tag flag |
| flag_wdata | input | 1 | New tag flag value |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_rdata | output | 128 | Load data, zero-extended |
| rsp_align_err | output | 1 | Misaligned quadword access rejected |
| tags_active | output | 1 | Current tags-active mode |
| tag_flag | output | 1 | Current tag flag |

## Verification
A stored tag is never visible directly, so a wrong tag stays hidden until the next aligned quadword load in tags-active mode reaches that granule. It then shows as a wrong `tag_flag` one cycle after that load is accepted. The bench therefore follows tag-changing stores with tags-active quadword loads, in both directed and random traffic. A wrong lane or byte-enable decode shows up as corrupted bytes on the next load of that granule. A wrong mode or flag update shows on `tags_active` or `tag_flag` in the cycle after the write.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

    localparam int GRAN_BYTES = 16;
    localparam int GRAN_BITS  = GRAN_BYTES * 8;
    localparam int LANE_W     = $clog2(GRAN_BYTES);

    // op[2] = store, op[1:0] = size code (0:1B 1:4B 2:8B 3:16B)
    typedef enum logic [2:0] {
        OP_LDB = 3'd0, OP_LDW = 3'd1, OP_LDD = 3'd2, OP_LDQ = 3'd3,
        OP_STB = 3'd4, OP_STW = 3'd5, OP_STD = 3'd6, OP_STQ = 3'd7
    } mem_op_e;

    typedef struct packed {
        logic                  wr;        // legal store
        logic                  rd;        // legal load
        logic                  err;       // misaligned quadword
        logic                  tag_load;  // quadword load feeding the flag
        logic                  tag_val;   // tag written by a store
        logic [GRAN_BYTES-1:0] ben;       // byte enables
        logic [LANE_W-1:0]     lane;      // first byte lane
        logic [1:0]            sz;        // size code
    } acc_dec_t;

    function automatic logic [LANE_W-1:0] lane_base(input logic [1:0] sz,
                                                    input logic [LANE_W-1:0] off);
        case (sz)
            2'd0:    return off;
            2'd1:    return {off[3:2], 2'b00};
            2'd2:    return {off[3], 3'b000};
            default: return '0;
        endcase
    endfunction

    function automatic logic [GRAN_BYTES-1:0] lane_mask(input logic [1:0] sz,
                                                        input logic [LANE_W-1:0] base);
        logic [GRAN_BYTES-1:0] m;
        case (sz)
            2'd0:    m = 16'h0001;
            2'd1:    m = 16'h000F;
            2'd2:    m = 16'h00FF;
            default: m = 16'hFFFF;
        endcase
        return m << base;
    endfunction

    function automatic logic [GRAN_BITS-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return {{(GRAN_BITS-8){1'b0}},  8'hFF};
            2'd1:    return {{(GRAN_BITS-32){1'b0}}, 32'hFFFF_FFFF};
            2'd2:    return {{(GRAN_BITS-64){1'b0}}, 64'hFFFF_FFFF_FFFF_FFFF};
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/tagmem_decode.sv
module tagmem_decode
    import tagmem_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [LANE_W-1:0] offset,
    input  logic              ta,
    input  logic              tflag,
    output acc_dec_t          dec
);

    logic is_store;
    logic is_quad;
    logic misal;

    always_comb begin
        is_store     = op[2];
        is_quad      = (op[1:0] == 2'b11);
        misal        = is_quad && (offset != '0);
        dec.sz       = op[1:0];
        dec.err      = misal;
        dec.wr       = is_store && !misal;
        dec.rd       = !is_store && !misal;
        dec.lane     = lane_base(op[1:0], offset);
        dec.ben      = lane_mask(op[1:0], dec.lane);
        dec.tag_val  = is_quad && ta && tflag;
        dec.tag_load = !is_store && is_quad && ta && !misal;
    end

endmodule

// File: rtl/tagmem_store.sv
module tagmem_store
    import tagmem_pkg::*;
#(
    parameter int GRANULES = 16,
    localparam int IDX_W   = $clog2(GRANULES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  wr_en,
    input  logic [GRAN_BYTES-1:0] ben,
    input  logic [GRAN_BITS-1:0]  wdata,
    input  logic                  tag_in,
    input  logic                  rd_en,
    output logic [GRAN_BITS-1:0]  rdata,
    output logic                  tag_peek
);

    logic [GRAN_BITS-1:0] data_q [GRANULES];
    logic [GRANULES-1:0]  tag_q;   // held alongside data, in check-bit storage
    logic [GRAN_BITS-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < GRANULES; g++) data_q[g] <= '0;
            tag_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < GRAN_BYTES; b++)
                if (ben[b]) data_q[idx][b*8 +: 8] <= wdata[b*8 +: 8];
            tag_q[idx] <= tag_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= data_q[idx];
    end

    assign rdata    = rdata_q;
    assign tag_peek = tag_q[idx];

    // R3
    bad_store_collision_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ben != '0));

endmodule

// File: rtl/tagmem_lsu.sv
module tagmem_lsu
    import tagmem_pkg::*;
#(
    parameter int GRANULES = 16,
    parameter int ADDR_W   = $clog2(GRANULES) + 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [GRAN_BITS-1:0] req_wdata,
    input  logic                 mode_we,
    input  logic                 mode_wdata,
    input  logic                 flag_we,
    input  logic                 flag_wdata,
    output logic                 rsp_valid,
    output logic [GRAN_BITS-1:0] rsp_rdata,
    output logic                 rsp_align_err,
    output logic                 tags_active,
    output logic                 tag_flag
);

    localparam int IDX_W = $clog2(GRANULES);

    logic                 acc;
    logic [IDX_W-1:0]     gidx;
    acc_dec_t             dec;
    logic [GRAN_BITS-1:0] wshift;
    logic [GRAN_BITS-1:0] raw;
    logic                 tag_peek;

    logic                 ta_q, tflag_q;
    logic                 rsp_q, err_q, ld_q;
    logic [LANE_W-1:0]    lane_q;
    logic [1:0]           sz_q;

    assign req_ready = !rst;
    assign acc       = req_valid && req_ready;
    assign gidx      = req_addr[ADDR_W-1:LANE_W];
    assign wshift    = req_wdata << {dec.lane, 3'b000};

    tagmem_decode u_dec (
        .op     (req_op),
        .offset (req_addr[LANE_W-1:0]),
        .ta     (ta_q),
        .tflag  (tflag_q),
        .dec    (dec)
    );

    tagmem_store #(.GRANULES(GRANULES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .idx      (gidx),
        .wr_en    (acc && dec.wr),
        .ben      (dec.ben),
        .wdata    (wshift),
        .tag_in   (dec.tag_val),
        .rd_en    (acc && dec.rd),
        .rdata    (raw),
        .tag_peek (tag_peek)
    );

    always_ff @(posedge clk) begin
        if (rst)          ta_q <= 1'b0;
        else if (mode_we) ta_q <= mode_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                        tflag_q <= 1'b0;
        else if (acc && dec.tag_load)   tflag_q <= tag_peek;
        else if (flag_we)               tflag_q <= flag_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q  <= 1'b0;
            err_q  <= 1'b0;
            ld_q   <= 1'b0;
            lane_q <= '0;
            sz_q   <= '0;
        end else begin
            rsp_q  <= acc;
            err_q  <= acc && dec.err;
            ld_q   <= acc && dec.rd;
            if (acc) begin
                lane_q <= dec.lane;
                sz_q   <= dec.sz;
            end
        end
    end

    assign rsp_valid     = rsp_q;
    assign rsp_align_err = err_q;
    assign rsp_rdata     = ld_q ? ((raw >> {lane_q, 3'b000}) & size_mask(sz_q)) : '0;
    assign tags_active   = ta_q;
    assign tag_flag      = tflag_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (!tags_active && !tag_flag && !rsp_valid && (u_store.tag_q == '0)));

    // R2
    rsp_follows_acc_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);

    // R2
    rsp_only_after_acc_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid);

    // R3
    ord_store_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op[2] && (req_op[1:0] != 2'b11))
        |=> (u_store.tag_q[$past(gidx)] == 1'b0));

    // R4
    quad_store_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && (req_op == OP_STQ) && ta_q && (req_addr[LANE_W-1:0] == '0))
        |=> (u_store.tag_q[$past(gidx)] == $past(tflag_q)));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_we && !(acc && (req_op == OP_LDQ) && ta_q)) |=> $stable(tag_flag));

    // R8
    misalign_err_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && (req_op[1:0] == 2'b11) && (req_addr[LANE_W-1:0] != '0))
        |=> (rsp_align_err && (rsp_rdata == '0)));

endmodule

// File: tb/tagmem_lsu_tb_top.sv
`timescale 1ns/1ps
module tagmem_lsu_tb_top;

    localparam int G  = 16;
    localparam int AW = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [2:0]   req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [127:0] req_wdata = '0;
    logic         mode_we = 1'b0, mode_wdata = 1'b0;
    logic         flag_we = 1'b0, flag_wdata = 1'b0;
    logic         rsp_valid;
    logic [127:0] rsp_rdata;
    logic         rsp_align_err;
    logic         tags_active, tag_flag;

    int tests = 0;
    int fails = 0;

    logic [7:0] mem_m [G][16];
    logic       tag_m [G];
    logic       ta_m, tf_m;

    always #2 clk = ~clk;

    tagmem_lsu #(.GRANULES(G), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_align_err(rsp_align_err),
        .tags_active(tags_active), .tag_flag(tag_flag)
    );

    task automatic chk(input string r, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 0) ? 1 : (sz == 1) ? 4 : (sz == 2) ? 8 : 16;
    endfunction

    function automatic string op_req(input logic [2:0] op, input logic err);
        if (err)              return "R8";
        if (op == 3'd7)       return ta_m ? "R4" : "R6";
        if (op == 3'd3)       return ta_m ? "R5" : "R6";
        if (op[2])            return "R3";
        return "R7";
    endfunction

    // one request plus optional control writes in the same cycle
    task automatic req(input logic [2:0] op, input logic [AW-1:0] addr,
                       input logic [127:0] wd, input logic mwe, input logic mv,
                       input logic fwe, input logic fv);
        logic [3:0]   g;
        logic [3:0]   off;
        int           n, base;
        logic         err;
        logic [127:0] exp_d;
        logic         new_tf;
        logic         tload;
        string        r;
        g   = addr[7:4];
        off = addr[3:0];
        n   = nbytes(op[1:0]);
        base = (int'(off) / n) * n;
        err = (op[1:0] == 2'b11) && (off != 0);
        r   = op_req(op, err);
        exp_d = '0;
        tload = 1'b0;
        new_tf = tf_m;
        if (!err) begin
            if (!op[2]) begin
                for (int i = 0; i < n; i++) exp_d[i*8 +: 8] = mem_m[g][base+i];
                if (op[1:0] == 2'b11 && ta_m) begin tload = 1'b1; new_tf = tag_m[g]; end
            end else begin
                for (int i = 0; i < n; i++) mem_m[g][base+i] = wd[i*8 +: 8];
                tag_m[g] = (op[1:0] == 2'b11 && ta_m) ? tf_m : 1'b0;
            end
        end
        if (mwe) ta_m = mv;
        if (tload) tf_m = new_tf;
        else if (fwe) begin tf_m = fv; r = {r, "/R9"}; end
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        mode_we = mwe; mode_wdata = mv; flag_we = fwe; flag_wdata = fv;
        @(negedge clk);
        req_valid = 1'b0; mode_we = 1'b0; flag_we = 1'b0;
        chk({r, " rsp_valid"}, {127'd0, rsp_valid}, 128'd1);
        chk({r, " rdata"}, rsp_rdata, exp_d);
        chk({r, " align_err"}, {127'd0, rsp_align_err}, {127'd0, err});
        chk({r, " tag_flag"}, {127'd0, tag_flag}, {127'd0, tf_m});
        chk({r, " tags_active"}, {127'd0, tags_active}, {127'd0, ta_m});
    endtask

    task automatic ctl(input logic mwe, input logic mv, input logic fwe, input logic fv);
        if (mwe) ta_m = mv;
        if (fwe) tf_m = fv;
        @(negedge clk);
        mode_we = mwe; mode_wdata = mv; flag_we = fwe; flag_wdata = fv;
        @(negedge clk);
        mode_we = 1'b0; flag_we = 1'b0;
        chk("R9 mode", {127'd0, tags_active}, {127'd0, ta_m});
        chk("R9 flag", {127'd0, tag_flag}, {127'd0, tf_m});
        chk("R2 idle rsp", {127'd0, rsp_valid}, 128'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [127:0] pat;
        void'($urandom(32'h5EED_1234));
        for (int g = 0; g < G; g++) begin
            tag_m[g] = 1'b0;
            for (int b = 0; b < 16; b++) mem_m[g][b] = 8'h00;
        end
        ta_m = 1'b0; tf_m = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tags_active", {127'd0, tags_active}, 128'd0);
        chk("R1 tag_flag", {127'd0, tag_flag}, 128'd0);
        chk("R1 rsp_valid", {127'd0, rsp_valid}, 128'd0);
        chk("R2 ready", {127'd0, req_ready}, 128'd1);

        pat = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
        ctl(1'b1, 1'b1, 1'b0, 1'b0);
        for (int g = 0; g < G; g++) req(3'd3, {g[3:0], 4'h0}, '0, 0, 0, 0, 0);   // R1 all tags zero
        ctl(1'b0, 1'b0, 1'b1, 1'b1);
        req(3'd7, 8'h50, pat, 0, 0, 0, 0);          // R4 tag=1
        ctl(1'b0, 1'b0, 1'b1, 1'b0);
        req(3'd3, 8'h50, '0, 0, 0, 0, 0);           // R5 flag<=1
        req(3'd4, 8'h53, 128'hAA, 0, 0, 0, 0);      // R3 byte store clears
        req(3'd3, 8'h50, '0, 0, 0, 0, 0);           // R5 flag<=0
        req(3'd0, 8'h53, '0, 0, 0, 0, 0);           // R7 byte
        req(3'd1, 8'h56, '0, 0, 0, 0, 0);           // R7 word
        req(3'd2, 8'h5C, '0, 0, 0, 0, 0);           // R7 dword
        ctl(1'b0, 1'b0, 1'b1, 1'b1);
        req(3'd7, 8'h60, ~pat, 0, 0, 0, 0);         // R4
        req(3'd1, 8'h60, '0, 0, 0, 0, 0);           // R7 flag stays 1
        ctl(1'b1, 1'b0, 1'b1, 1'b0);
        req(3'd3, 8'h60, '0, 0, 0, 0, 0);           // R6 flag unchanged
        ctl(1'b0, 1'b0, 1'b1, 1'b1);
        req(3'd7, 8'h60, pat, 0, 0, 0, 0);          // R6 clears tag
        ctl(1'b1, 1'b1, 1'b0, 1'b0);
        req(3'd3, 8'h60, '0, 0, 0, 0, 0);           // R6 via flag=0
        ctl(1'b0, 1'b0, 1'b1, 1'b1);
        req(3'd7, 8'h73, pat, 0, 0, 0, 0);          // R8 misaligned store
        req(3'd3, 8'h70, '0, 0, 0, 0, 0);           // R8 nothing written
        ctl(1'b0, 1'b0, 1'b1, 1'b1);
        req(3'd3, 8'h58, '0, 0, 0, 0, 0);           // R8 misaligned load
        req(3'd7, 8'h80, pat, 0, 0, 0, 0);          // tag 8 = 1
        req(3'd3, 8'h50, '0, 0, 0, 1, 1);           // R9 load wins (tag 0)
        req(3'd3, 8'h80, '0, 0, 0, 1, 0);           // R9 load wins (tag 1)
        req(3'd7, 8'h90, pat, 1, 0, 0, 0);          // R9 old mode used
        req(3'd3, 8'h90, '0, 0, 0, 0, 0);

        for (int k = 0; k < 600; k++) begin
            logic [2:0]  op;
            logic [7:0]  a;
            logic [127:0] wd;
            op = 3'($urandom % 8);
            a  = 8'($urandom);
            if (op[1:0] == 2'b11 && ($urandom % 4) != 0) a[3:0] = 4'h0;
            wd = {$urandom, $urandom, $urandom, $urandom};
            req(op, a, wd, ($urandom % 10) == 0, 1'($urandom), ($urandom % 6) == 0, 1'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule